// File: doc/BRIEF.md
# Four-Channel PWM Generator with Latched Fault Override

This block produces four pulse-width-modulated outputs from one free-running 12-bit up-counter. Each channel compares its own 12-bit duty value against the counter. A channel output is high from counter wrap-around until the counter reaches the duty value, and low for the rest of the period. Software reaches a small byte-wide register port to set the duty values, a per-channel output enable and a fault control byte.

A fault source is either an external fault pin or an internal comparator result. The source is selected in the fault control byte, and so is the level that counts as active. The chosen signal passes through a two-flop synchroniser. When it shows its active level, a sticky fault flag is raised. While the flag is set, every enabled output is driven to a static four-bit safe pattern held in the same byte. The flag drops only when software writes it to zero after the fault level has gone away.

Duty writes land in shadow registers. They are copied into the compare registers when the counter wraps, so every period uses one consistent duty value.

Top module: `pwm_fault_override`

## Requirements
- R1: After reset the control byte reads 00h, the output-enable byte and every duty byte read 00h, the counter is 0 and all four outputs are low.
- R2: The counter steps by one each clock, from 0 to 4095, and then wraps to 0. An enabled channel with no fault is high while counter < duty and low otherwise. A duty of 0 keeps the output low for the whole period.
- R3: A duty write goes to a shadow register. The compare value changes only when the counter wraps from 4095 to 0, so the output follows the old duty until the end of the current period.
- R4: Channel c (0 to 3) has its duty bits 11:8 at address 2c+1, in data bits 3:0, with bits 7:4 reading 0. Its duty bits 7:0 are at address 2c+2. Reads return the shadow value.
- R5: Control byte (address 0) bit 7 selects the fault source: 0 is the fault pin, 1 is the comparator input. The source that is not selected has no effect on the flag.
- R6: Control bit 6 sets the active level: 0 means a low level is active, 1 means a high level is active. The inactive level never raises the flag.
- R7: Control bit 4 enables the fault pin. When it is 0 the pin cannot raise the flag. The comparator source does not depend on this bit.
- R8: Control bit 5 is the fault flag. It is set 3 clock edges after the selected source takes its active level, and it stays set after the level goes away. A software write of 0 clears it only while the source is not active. A software write of 1 sets it.
- R9: While the flag is set, each enabled output c is driven to control bit c (the safe pattern in bits 3:0) in place of its PWM waveform.
- R10: The output-enable byte is at address 9, with bit c for channel c. A channel whose enable bit is 0 is held low, with or without a fault.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe, sampled on the clock edge |
| addr | input | 4 | Register address for reads and writes |
| wdata | input | 8 | Register write data |
| rdata | output | 8 | Register read data, combinational from addr |
| flt_pin | input | 1 | External fault pin, asynchronous |
| cmp_in | input | 1 | Internal comparator result, asynchronous |
| pwm_out | output | 4 | PWM outputs, bit c for channel c |

## Verification
The PWM compare is tried with four duty values on four channels at the same time: 0, 1, the midpoint and the full-scale value. Sampling at the counter values on each side of every boundary separates a correct strict less-than compare from an off-by-one or less-or-equal compare, and shows whether the two extreme duties are treated as special cases. The fault path is tried with each combination of source, level and pin enable driven to active and inactive levels. This separates a wrong source mux, an inverted active level and a missing pin gate. Clear attempts are made both while the fault is still present and after it has gone, which separates a sticky flag from a plain follower of the fault level.

// File: rtl/pwmfo_pkg.sv
package pwmfo_pkg;
    localparam int CNT_W  = 12;
    localparam int NCH    = 4;
    localparam int ADDR_W = 4;
    localparam int BYTE_W = 8;
    localparam int HI_W   = CNT_W - BYTE_W;

    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] A_OE   = ADDR_W'(9);

    typedef logic [CNT_W-1:0] cnt_t;

    // Control byte layout, most significant field first
    typedef struct packed {
        logic           src_cmp;   // 1: comparator source, 0: pin
        logic           act_high;  // 1: high level active
        logic           flag;      // sticky fault flag
        logic           pin_en;    // pin source enable
        logic [NCH-1:0] pattern;   // safe output pattern
    } ctrl_t;

    function automatic logic [ADDR_W-1:0] hi_addr(input int ch);
        return ADDR_W'(2 * ch + 1);
    endfunction

    function automatic logic [ADDR_W-1:0] lo_addr(input int ch);
        return ADDR_W'(2 * ch + 2);
    endfunction
endpackage

// File: rtl/pwmfo_sync.sv
module pwmfo_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/pwmfo_fault.sv
module pwmfo_fault #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_raw,
    input  logic cmp_raw,
    input  logic src_cmp,
    input  logic act_high,
    input  logic pin_en,
    output logic active
);
    logic pin_s, cmp_s, level, armed;

    pwmfo_sync #(.STAGES(SYNC_STAGES)) u_pin_sync (
        .clk(clk), .rst(rst), .d(pin_raw), .q(pin_s)
    );
    pwmfo_sync #(.STAGES(SYNC_STAGES)) u_cmp_sync (
        .clk(clk), .rst(rst), .d(cmp_raw), .q(cmp_s)
    );

    always_comb begin
        level  = src_cmp ? cmp_s : pin_s;
        armed  = src_cmp | pin_en;
        active = armed && (level == act_high);
    end
endmodule

// File: rtl/pwmfo_regs.sv
module pwmfo_regs
    import pwmfo_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_en,
    input  logic [ADDR_W-1:0]          addr,
    input  logic [BYTE_W-1:0]          wdata,
    input  logic                       fault_active,
    output logic [BYTE_W-1:0]          rdata,
    output ctrl_t                      ctrl_q,
    output logic [NCH-1:0]             oe_q,
    output logic [NCH-1:0][CNT_W-1:0]  duty_sh
);
    ctrl_t wr_view;
    logic  wr_ctrl;

    assign wr_view = ctrl_t'(wdata);
    assign wr_ctrl = wr_en && (addr == A_CTRL);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= '0;
            oe_q    <= '0;
            duty_sh <= '0;
        end else begin
            if (wr_ctrl) begin
                ctrl_q.src_cmp  <= wr_view.src_cmp;
                ctrl_q.act_high <= wr_view.act_high;
                ctrl_q.pin_en   <= wr_view.pin_en;
                ctrl_q.pattern  <= wr_view.pattern;
            end
            ctrl_q.flag <= (wr_ctrl ? wr_view.flag : ctrl_q.flag) | fault_active;
            if (wr_en && addr == A_OE) oe_q <= wdata[NCH-1:0];
            for (int c = 0; c < NCH; c++) begin
                if (wr_en && addr == hi_addr(c))
                    duty_sh[c][CNT_W-1:BYTE_W] <= wdata[HI_W-1:0];
                if (wr_en && addr == lo_addr(c))
                    duty_sh[c][BYTE_W-1:0] <= wdata;
            end
        end
    end

    always_comb begin
        rdata = '0;
        if (addr == A_CTRL) rdata = ctrl_q;
        if (addr == A_OE)   rdata = BYTE_W'(oe_q);
        for (int c = 0; c < NCH; c++) begin
            if (addr == hi_addr(c)) rdata = BYTE_W'(duty_sh[c][CNT_W-1:BYTE_W]);
            if (addr == lo_addr(c)) rdata = duty_sh[c][BYTE_W-1:0];
        end
    end
endmodule

// File: rtl/pwmfo_chan.sv
module pwmfo_chan
    import pwmfo_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  cnt_t cnt,
    input  cnt_t duty_sh,
    input  logic en,
    input  logic brk,
    input  logic safe_bit,
    output logic out,
    output cnt_t duty_act
);
    logic wave;

    always_ff @(posedge clk) begin
        if (rst)       duty_act <= '0;
        else if (load) duty_act <= duty_sh;
    end

    always_comb begin
        wave = (cnt < duty_act);
        out  = en & (brk ? safe_bit : wave);
    end
endmodule

// File: rtl/pwm_fault_override.sv
module pwm_fault_override
    import pwmfo_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] rdata,
    input  logic              flt_pin,
    input  logic              cmp_in,
    output logic [NCH-1:0]    pwm_out
);
    ctrl_t                      ctrl_q;
    logic [NCH-1:0]             oe_q;
    logic [NCH-1:0][CNT_W-1:0]  duty_sh;
    logic [NCH-1:0][CNT_W-1:0]  duty_act;
    logic                       fault_active;
    cnt_t                       cnt;
    logic                       wrap;

    always_ff @(posedge clk) begin
        if (rst) cnt <= '0;
        else     cnt <= cnt + cnt_t'(1);
    end
    assign wrap = (cnt == '1);

    pwmfo_regs u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .fault_active(fault_active), .rdata(rdata), .ctrl_q(ctrl_q),
        .oe_q(oe_q), .duty_sh(duty_sh)
    );

    pwmfo_fault #(.SYNC_STAGES(SYNC_STAGES)) u_fault (
        .clk(clk), .rst(rst), .pin_raw(flt_pin), .cmp_raw(cmp_in),
        .src_cmp(ctrl_q.src_cmp), .act_high(ctrl_q.act_high),
        .pin_en(ctrl_q.pin_en), .active(fault_active)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        pwmfo_chan u_chan (
            .clk(clk), .rst(rst), .load(wrap), .cnt(cnt),
            .duty_sh(duty_sh[c]), .en(oe_q[c]), .brk(ctrl_q.flag),
            .safe_bit(ctrl_q.pattern[c]), .out(pwm_out[c]),
            .duty_act(duty_act[c])
        );
    end
endmodule

// File: rtl/pwmfo_checker.sv
module pwmfo_checker
    import pwmfo_pkg::*;
(
    input logic                      clk,
    input logic                      rst,
    input logic                      wr_en,
    input logic [NCH-1:0]            pwm_out,
    input logic [NCH-1:0]            oe,
    input logic [NCH-1:0]            pattern,
    input logic                      flag,
    input logic                      fault_active,
    input logic                      src_cmp,
    input logic                      pin_en,
    input logic [CNT_W-1:0]          cnt,
    input logic [NCH-1:0][CNT_W-1:0] duty_act
);
    AST_DISABLED_LOW: assert property (@(posedge clk) disable iff (rst)
        (pwm_out & ~oe) == '0);  // R10

    AST_SAFE_PATTERN: assert property (@(posedge clk) disable iff (rst)
        flag |-> pwm_out == (pattern & oe));  // R9

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        (flag && fault_active) |=> flag);  // R8

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
        (cnt != '1) |=> (cnt == $past(cnt) + CNT_W'(1)));  // R2

    AST_DUTY_HOLD: assert property (@(posedge clk) disable iff (rst)
        (cnt != '1) |=> $stable(duty_act));  // R3

    AST_PIN_GATED: assert property (@(posedge clk) disable iff (rst)
        (!src_cmp && !pin_en && !flag && !wr_en) |=> !flag);  // R7
endmodule

bind pwm_fault_override pwmfo_checker u_chk (
    .clk(clk), .rst(rst), .wr_en(wr_en), .pwm_out(pwm_out), .oe(oe_q),
    .pattern(ctrl_q.pattern), .flag(ctrl_q.flag), .fault_active(fault_active),
    .src_cmp(ctrl_q.src_cmp), .pin_en(ctrl_q.pin_en), .cnt(cnt),
    .duty_act(duty_act)
);

// File: tb/pwm_fault_override_test.sv
module pwm_fault_override_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [3:0] addr = 4'd0;
    logic [7:0] wdata = 8'd0;
    logic [7:0] rdata;
    logic       flt_pin = 1'b0;
    logic       cmp_in = 1'b0;
    logic [3:0] pwm_out;

    int total = 0;
    int fails = 0;
    logic done = 1'b0;
    logic [11:0] mcnt;
    logic [7:0]  rd_v;

    always #4 clk = ~clk;

    pwm_fault_override uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .flt_pin(flt_pin), .cmp_in(cmp_in), .pwm_out(pwm_out)
    );

    // Independent model of the free-running period counter (R2)
    always @(posedge clk) begin
        if (rst) mcnt <= 12'd0;
        else     mcnt <= mcnt + 12'd1;
    end

    // duty: ch0=0, ch1=1, ch2=800h, ch3=FFFh; entry = {counter, expected outputs}
    localparam logic [15:0] VEC [6] = '{
        {12'h000, 4'b1110}, {12'h001, 4'b1100}, {12'h7FF, 4'b1100},
        {12'h800, 4'b1000}, {12'hFFE, 4'b1000}, {12'hFFF, 4'b0000}
    };

    task automatic check(input string req, input logic [11:0] act, input logic [11:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; addr = 4'd0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic wait_cnt(input logic [11:0] v);
        do @(negedge clk); while (mcnt != v);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        rd(4'd0, rd_v); check("R1 ctrl", 12'(rd_v), 12'h00);
        rd(4'd9, rd_v); check("R1 oe", 12'(rd_v), 12'h00);
        rd(4'd5, rd_v); check("R1 duty", 12'(rd_v), 12'h00);
        check("R1 outputs", 12'(pwm_out), 12'h0);

        // Program duties and enables (R4, R10)
        wr(4'd9, 8'h0F);
        wr(4'd4, 8'h01);
        wr(4'd5, 8'h08); wr(4'd6, 8'h00);
        wr(4'd7, 8'h0F); wr(4'd8, 8'hFF);
        rd(4'd5, rd_v); check("R4 ch2 high", 12'(rd_v), 12'h08);
        rd(4'd8, rd_v); check("R4 ch3 low", 12'(rd_v), 12'hFF);
        wait_cnt(12'hFFF);
        for (int i = 0; i < 6; i++) begin
            wait_cnt(VEC[i][15:4]);
            check("R2 compare", 12'(pwm_out), 12'(VEC[i][3:0]));
        end

        // R3 shadow update at wrap
        wait_cnt(12'h010);
        wr(4'd1, 8'h01); wr(4'd2, 8'h00);
        wait_cnt(12'h050); check("R3 old duty kept", 12'(pwm_out[0]), 12'h0);
        wait_cnt(12'h050); check("R3 new duty high", 12'(pwm_out[0]), 12'h1);
        wait_cnt(12'h100); check("R3 new duty end", 12'(pwm_out[0]), 12'h0);

        // R7 pin disabled: level has no effect
        wr(4'd9, 8'h07);
        wr(4'd0, 8'h4A);
        flt_pin = 1'b1; idle(5);
        rd(4'd0, rd_v); check("R7 pin ignored", 12'(rd_v), 12'h4A);
        wait_cnt(12'h020); check("R10 enabled normal", 12'(pwm_out), 12'h5);

        // R8 latency and R9 override
        flt_pin = 1'b0; idle(3);
        wr(4'd0, 8'h5A); idle(3);
        rd(4'd0, rd_v); check("R6 inactive level", 12'(rd_v), 12'h5A);
        flt_pin = 1'b1;
        @(negedge clk); @(negedge clk);
        check("R8 not yet set", 12'(rdata[5]), 12'h0);
        @(negedge clk);
        check("R8 set after 3 edges", 12'(rdata[5]), 12'h1);
        check("R9 safe pattern", 12'(pwm_out), 12'h2);
        wr(4'd0, 8'h5A);
        rd(4'd0, rd_v); check("R8 clear blocked", 12'(rd_v), 12'h7A);
        flt_pin = 1'b0; idle(4);
        rd(4'd0, rd_v); check("R8 sticky", 12'(rd_v), 12'h7A);
        wr(4'd0, 8'h5A);
        rd(4'd0, rd_v); check("R8 cleared", 12'(rd_v), 12'h5A);
        wait_cnt(12'h020); check("R9 waveform back", 12'(pwm_out), 12'h5);

        // R6 low-active level
        wr(4'd0, 8'h0A);
        flt_pin = 1'b1; idle(3);
        wr(4'd0, 8'h1A); idle(4);
        rd(4'd0, rd_v); check("R6 high ignored", 12'(rd_v), 12'h1A);
        flt_pin = 1'b0; idle(3);
        rd(4'd0, rd_v); check("R6 low active", 12'(rd_v), 12'h3A);
        flt_pin = 1'b1; idle(3);
        wr(4'd0, 8'h1A);
        rd(4'd0, rd_v); check("R8 clear after level gone", 12'(rd_v), 12'h1A);

        // R5 comparator source
        wr(4'd0, 8'hCA); idle(4);
        rd(4'd0, rd_v); check("R5 pin ignored on cmp source", 12'(rd_v), 12'hCA);
        cmp_in = 1'b1; idle(3);
        rd(4'd0, rd_v); check("R5 cmp sets flag", 12'(rd_v), 12'hEA);
        cmp_in = 1'b0; idle(3);
        wr(4'd0, 8'hCA);
        rd(4'd0, rd_v); check("R5 cmp cleared", 12'(rd_v), 12'hCA);

        // R8 software set
        wr(4'd0, 8'hEA);
        rd(4'd0, rd_v); check("R8 software set", 12'(rd_v), 12'hEA);
        check("R9 pattern on software set", 12'(pwm_out), 12'h2);
        check("R10 disabled low in fault", 12'(pwm_out[3]), 12'h0);
        wr(4'd0, 8'hCA);

        // R4 reserved bits
        wr(4'd1, 8'hFF);
        rd(4'd1, rd_v); check("R4 reserved zero", 12'(rd_v), 12'h0F);
        rd(4'd2, rd_v); check("R4 low byte", 12'(rd_v), 12'h00);

        // R1 reset again
        rst = 1'b1; idle(2); rst = 1'b0;
        rd(4'd0, rd_v); check("R1 ctrl after reset", 12'(rd_v), 12'h00);
        rd(4'd1, rd_v); check("R1 duty after reset", 12'(rd_v), 12'h00);
        check("R1 outputs after reset", 12'(pwm_out), 12'h0);

        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end
endmodule